// File: doc/BRIEF.md
# Translation fault capture unit

This block sits beside an address translator and records the context of the first translation fault that the translator reports. When a fault with at least one enabled cause arrives and nothing is pending yet, the unit stores the cause bits, the faulting I/O virtual address, the physical address involved and the requester ID. It then raises a level interrupt. Software reads the stored values over a simple register bus. The bus has a write strobe, a word address and combinational read data. Software acknowledges the fault by writing a self-clearing clear bit in the enable register.

The unit also holds the translator's static settings. These are a coherency enable, a two-bit protect select, and a protect physical address aligned to 128 bytes, to which faulted accesses are redirected. It also splits the requester ID into a local-arbiter number and a port number for software. The translator does not say whether a fault was a read or a write, so no such field exists.

Top module: `xlat_fault_capture`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. Register word addresses are 0 control, 1 protect address, 2 enable, 3 cause, 4 IOVA, 5 PA, 6 requester ID and 7 decoded requester.
- R2: The control register keeps bit 8 as the coherency enable and bits [6:5] as the protect select. It drives `coherent_en` and `prot_sel` from these bits, and all its other bits read 0.
- R3: The protect address register forces bits [6:0] to 0 on write and drives `protect_pa` with the stored value.
- R4: Enable register bits [7:0] enable one fault cause each. A fault whose cause bits are all disabled is not recorded and does not raise `irq`.
- R5: The first fault with an enabled cause is recorded on the clock edge where `flt_valid` is high. The recorded values are the raw cause bits, the IOVA with bits [11:0] cleared, the PA and the requester ID. `irq` is high from the cycle after that edge.
- R6: While a fault is pending, later faults are ignored, and the recorded values do not change.
- R7: `irq` is high only while a fault is pending and at least one recorded cause bit is enabled. Masking the recorded cause drops `irq`, and unmasking it raises `irq` again.
- R8: A write to the enable register with bit 12 set clears the pending fault and the cause register, and `irq` is low on the next cycle. Such a write leaves enable bits [7:0] unchanged, and bit 12 always reads 0.
- R9: A fault that arrives in the same cycle as a clear write is dropped.
- R10: The decoded register holds the port, equal to requester ID bits [11:8], in bits [3:0]. It holds the arbiter number, equal to 6 minus requester ID bits [15:13] taken modulo 8, in bits [10:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| flt_valid | input | 1 | Translator reports a fault this cycle |
| flt_cause | input | 8 | Fault cause bits |
| flt_iova | input | 32 | Faulting I/O virtual address |
| flt_pa | input | 32 | Physical address involved |
| flt_rid | input | 16 | Requester ID |
| irq | output | 1 | Level fault interrupt |
| coherent_en | output | 1 | Coherency enable to translator |
| prot_sel | output | 2 | Protect select to translator |
| protect_pa | output | 32 | Redirect address for faulted accesses |

## Verification
The assertions check several rules on every cycle. They check that `irq` never rises without a recorded cause. They check that a clear write drops `irq` and leaves the enables as they were. They check that recorded values hold while a fault is pending, that an enabled fault arriving while nothing is pending raises `irq`, and that the protect address stays aligned. The bench scenarios cover the values themselves. These are the field masking of the control register, the IOVA page truncation, the arbiter subtraction wrapping to 7, the loss of a fault that collides with a clear, and the recording of a new fault after a clear.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_PROT  = 3'd1,
    RA_INTEN = 3'd2,
    RA_CAUSE = 3'd3,
    RA_IOVA  = 3'd4,
    RA_PA    = 3'd5,
    RA_RID   = 3'd6,
    RA_DEC   = 3'd7
  } reg_addr_e;

  localparam int CLR_BIT  = 12;
  localparam int COH_BIT  = 8;
  localparam int PSEL_LSB = 5;
  localparam int PSEL_W   = 2;

  // requester ID field positions
  localparam int RID_PORT_LSB = 8;
  localparam int RID_PORT_W   = 4;
  localparam int RID_ARB_LSB  = 13;
  localparam int RID_ARB_W    = 3;
  localparam int ARB_BASE     = 6;
  // decoded register layout
  localparam int DEC_ARB_LSB  = 8;
endpackage

// File: rtl/fcap_rst_sync.sv
module fcap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fcap_cfg_regs.sv
module fcap_cfg_regs
  import fcap_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NCAUSE     = 8,
  parameter int ALIGN_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [REG_AW-1:0]   addr,
  input  logic [DW-1:0]       wdata,
  output logic                coh_q,
  output logic [PSEL_W-1:0]   psel_q,
  output logic [DW-1:0]       prot_q,
  output logic [NCAUSE-1:0]   en_q,
  output logic                clr_pulse
);
  logic              coh_d;
  logic [PSEL_W-1:0] psel_d;
  logic [DW-1:0]     prot_d;
  logic [NCAUSE-1:0] en_d;
  logic              wr_ctrl, wr_prot, wr_en;

  assign wr_ctrl   = we && (addr == RA_CTRL);
  assign wr_prot   = we && (addr == RA_PROT);
  assign wr_en     = we && (addr == RA_INTEN);
  assign clr_pulse = wr_en && wdata[CLR_BIT];

  always_comb begin
    coh_d  = coh_q;
    psel_d = psel_q;
    prot_d = prot_q;
    en_d   = en_q;
    if (wr_ctrl) begin
      coh_d  = wdata[COH_BIT];
      psel_d = wdata[PSEL_LSB +: PSEL_W];
    end
    if (wr_prot) prot_d = {wdata[DW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    if (wr_en && !wdata[CLR_BIT]) en_d = wdata[NCAUSE-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coh_q  <= 1'b0;
      psel_q <= '0;
      prot_q <= '0;
      en_q   <= '0;
    end else begin
      coh_q  <= coh_d;
      psel_q <= psel_d;
      prot_q <= prot_d;
      en_q   <= en_d;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[ALIGN_BITS-1:0]};
endmodule

// File: rtl/fcap_latch.sv
module fcap_latch #(
  parameter int DW        = 32,
  parameter int NCAUSE    = 8,
  parameter int RID_W     = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [NCAUSE-1:0] en,
  input  logic              flt_valid,
  input  logic [NCAUSE-1:0] flt_cause,
  input  logic [DW-1:0]     flt_iova,
  input  logic [DW-1:0]     flt_pa,
  input  logic [RID_W-1:0]  flt_rid,
  output logic              pend_q,
  output logic [NCAUSE-1:0] cause_q,
  output logic [DW-1:0]     iova_q,
  output logic [DW-1:0]     pa_q,
  output logic [RID_W-1:0]  rid_q
);
  logic              take;
  logic              pend_d;
  logic [NCAUSE-1:0] cause_d;

  // first enabled fault only; a clear in the same cycle wins
  assign take = flt_valid && |(flt_cause & en) && !pend_q && !clr;

  always_comb begin
    pend_d  = pend_q;
    cause_d = cause_q;
    if (clr) begin
      pend_d  = 1'b0;
      cause_d = '0;
    end else if (take) begin
      pend_d  = 1'b1;
      cause_d = flt_cause;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      pend_q  <= pend_d;
      cause_q <= cause_d;
    end
  end

  // context registers, enabled only on capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iova_q <= '0;
      pa_q   <= '0;
      rid_q  <= '0;
    end else if (take) begin
      iova_q <= {flt_iova[DW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      pa_q   <= flt_pa;
      rid_q  <= flt_rid;
    end
  end

  logic unused_pagebits;
  assign unused_pagebits = ^flt_iova[PAGE_BITS-1:0];
endmodule

// File: rtl/fcap_rid_decode.sv
module fcap_rid_decode
  import fcap_pkg::*;
#(
  parameter int RID_W = 16
) (
  input  logic [RID_W-1:0]      rid,
  output logic [RID_ARB_W-1:0]  arb,
  output logic [RID_PORT_W-1:0] port
);
  localparam logic [RID_ARB_W-1:0] BASE = RID_ARB_W'(ARB_BASE);

  assign arb  = BASE - rid[RID_ARB_LSB +: RID_ARB_W];
  assign port = rid[RID_PORT_LSB +: RID_PORT_W];

  logic unused_ridbits;
  assign unused_ridbits = ^{rid[RID_W-1:RID_ARB_LSB+RID_ARB_W], rid[RID_ARB_LSB-1:RID_PORT_LSB+RID_PORT_W],
                            rid[RID_PORT_LSB-1:0]};
endmodule

// File: rtl/xlat_fault_capture.sv
module xlat_fault_capture
  import fcap_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NCAUSE     = 8,
  parameter int RID_W      = 16,
  parameter int PAGE_BITS  = 12,
  parameter int ALIGN_BITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              flt_valid,
  input  logic [NCAUSE-1:0] flt_cause,
  input  logic [DW-1:0]     flt_iova,
  input  logic [DW-1:0]     flt_pa,
  input  logic [RID_W-1:0]  flt_rid,
  output logic              irq,
  output logic              coherent_en,
  output logic [PSEL_W-1:0] prot_sel,
  output logic [DW-1:0]     protect_pa
);
  logic                  rst_sync_n;
  logic [NCAUSE-1:0]     en_q;
  logic                  clr_pulse;
  logic                  pend_q;
  logic [NCAUSE-1:0]     cause_q;
  logic [DW-1:0]         iova_q;
  logic [DW-1:0]         pa_q;
  logic [RID_W-1:0]      rid_q;
  logic [RID_ARB_W-1:0]  dec_arb;
  logic [RID_PORT_W-1:0] dec_port;

  fcap_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  fcap_cfg_regs #(.DW(DW), .NCAUSE(NCAUSE), .ALIGN_BITS(ALIGN_BITS)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .coh_q(coherent_en), .psel_q(prot_sel), .prot_q(protect_pa),
    .en_q(en_q), .clr_pulse(clr_pulse)
  );

  fcap_latch #(.DW(DW), .NCAUSE(NCAUSE), .RID_W(RID_W), .PAGE_BITS(PAGE_BITS)) u_latch (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr_pulse), .en(en_q),
    .flt_valid(flt_valid), .flt_cause(flt_cause), .flt_iova(flt_iova),
    .flt_pa(flt_pa), .flt_rid(flt_rid),
    .pend_q(pend_q), .cause_q(cause_q), .iova_q(iova_q), .pa_q(pa_q), .rid_q(rid_q)
  );

  fcap_rid_decode #(.RID_W(RID_W)) u_dec (.rid(rid_q), .arb(dec_arb), .port(dec_port));

  assign irq = pend_q && |(cause_q & en_q);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL: begin
        reg_rdata[COH_BIT]             = coherent_en;
        reg_rdata[PSEL_LSB +: PSEL_W]  = prot_sel;
      end
      RA_PROT:  reg_rdata = protect_pa;
      RA_INTEN: reg_rdata[NCAUSE-1:0] = en_q;
      RA_CAUSE: reg_rdata[NCAUSE-1:0] = cause_q;
      RA_IOVA:  reg_rdata = iova_q;
      RA_PA:    reg_rdata = pa_q;
      RA_RID:   reg_rdata[RID_W-1:0] = rid_q;
      RA_DEC: begin
        reg_rdata[RID_PORT_W-1:0]             = dec_port;
        reg_rdata[DEC_ARB_LSB +: RID_ARB_W]   = dec_arb;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xlat_fault_capture_chk.sv
module xlat_fault_capture_chk
  import fcap_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NCAUSE     = 8,
  parameter int RID_W      = 16,
  parameter int ALIGN_BITS = 7
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic              flt_valid,
  input logic [NCAUSE-1:0] flt_cause,
  input logic              irq,
  input logic [DW-1:0]     protect_pa,
  input logic [NCAUSE-1:0] en_q,
  input logic              pend_q,
  input logic [NCAUSE-1:0] cause_q,
  input logic [DW-1:0]     iova_q,
  input logic [RID_W-1:0]  rid_q
);
  logic clr_wr;
  assign clr_wr = reg_we && (reg_addr == RA_INTEN) && reg_wdata[CLR_BIT];

  // R7: interrupt needs a recorded cause
  assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (cause_q != '0));

  // R8: clear drops the interrupt next cycle
  assert_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_wr |=> !irq);

  // R8: clear write leaves enables alone
  assert_clear_keeps_en_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_wr |=> $stable(en_q));

  // R6: recorded context holds while pending
  assert_first_fault_held_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend_q && !clr_wr) |=> ($stable(iova_q) && $stable(rid_q) && $stable(cause_q)));

  // R5: enabled fault with nothing pending raises irq
  assert_capture_raises_irq_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flt_valid && |(flt_cause & en_q) && !pend_q && !clr_wr && !reg_we) |=> irq);

  // R3: redirect address stays aligned
  assert_protect_aligned_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    protect_pa[ALIGN_BITS-1:0] == '0);
endmodule

bind xlat_fault_capture xlat_fault_capture_chk #(
  .DW(DW), .NCAUSE(NCAUSE), .RID_W(RID_W), .ALIGN_BITS(ALIGN_BITS)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .flt_valid(flt_valid), .flt_cause(flt_cause), .irq(irq),
  .protect_pa(protect_pa), .en_q(en_q), .pend_q(pend_q), .cause_q(cause_q),
  .iova_q(iova_q), .rid_q(rid_q)
);

// File: tb/xlat_fault_capture_bench.sv
`timescale 1ns/1ps
module xlat_fault_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        flt_valid;
  logic [7:0]  flt_cause;
  logic [31:0] flt_iova;
  logic [31:0] flt_pa;
  logic [15:0] flt_rid;
  logic        irq;
  logic        coherent_en;
  logic [1:0]  prot_sel;
  logic [31:0] protect_pa;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  xlat_fault_capture u_xlat_fault_capture (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_valid(flt_valid),
    .flt_cause(flt_cause), .flt_iova(flt_iova), .flt_pa(flt_pa), .flt_rid(flt_rid),
    .irq(irq), .coherent_en(coherent_en), .prot_sel(prot_sel), .protect_pa(protect_pa)
  );

  // kinds: 0 read data, 1 irq, 2 {coherent_en,prot_sel}, 3 protect_pa
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  // monitor: pops one expectation per cycle, 1 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0:       act = reg_rdata;
          1:       act = {31'b0, irq};
          2:       act = {29'b0, coherent_en, prot_sel};
          default: act = protect_pa;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic fault(input logic [7:0] c, input logic [31:0] va,
                       input logic [31:0] pa, input logic [15:0] rid);
    flt_valid = 1'b1; flt_cause = c; flt_iova = va; flt_pa = pa; flt_rid = rid;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    flt_valid = 1'b0; flt_cause = '0; flt_iova = '0; flt_pa = '0; flt_rid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(0, 3'd0, 32'h0, "R1 ctrl");
    chk(0, 3'd2, 32'h0, "R1 enable");
    chk(0, 3'd3, 32'h0, "R1 cause");
    chk(1, 3'd0, 32'h0, "R1 irq");

    // R2 control fields
    wr(3'd0, 32'hFFFF_FFFF);
    chk(0, 3'd0, 32'h0000_0160, "R2 ctrl readback all ones");
    chk(2, 3'd0, 32'h7, "R2 ctrl outputs");
    wr(3'd0, 32'h0000_0140);
    chk(2, 3'd0, 32'h6, "R2 ctrl outputs psel=2");

    // R3 protect address alignment
    wr(3'd1, 32'h1234_56FF);
    chk(0, 3'd1, 32'h1234_5680, "R3 protect readback");
    chk(3, 3'd1, 32'h1234_5680, "R3 protect output");

    // R4 disabled causes ignored
    fault(8'h01, 32'h1, 32'h2, 16'h3);
    chk(1, 3'd3, 32'h0, "R4 irq with all disabled");
    chk(0, 3'd3, 32'h0, "R4 cause with all disabled");
    wr(3'd2, 32'h0000_0005);
    fault(8'h02, 32'h1, 32'h2, 16'h3);
    chk(1, 3'd3, 32'h0, "R4 irq for masked cause");
    chk(0, 3'd2, 32'h5, "R4 enable readback");

    // R5 capture, R10 decode
    fault(8'h01, 32'hABCD_E123, 32'h8765_4321, 16'hA500);
    chk(1, 3'd3, 32'h1, "R5 irq raised");
    chk(0, 3'd3, 32'h1, "R5 cause");
    chk(0, 3'd4, 32'hABCD_E000, "R5 iova page");
    chk(0, 3'd5, 32'h8765_4321, "R5 pa");
    chk(0, 3'd6, 32'h0000_A500, "R5 rid");
    chk(0, 3'd7, 32'h0000_0105, "R10 decode arb=1 port=5");

    // R6 later fault ignored
    fault(8'h04, 32'h1111_1FFF, 32'h2222_2222, 16'h0300);
    chk(0, 3'd4, 32'hABCD_E000, "R6 iova held");
    chk(0, 3'd3, 32'h1, "R6 cause held");
    chk(0, 3'd5, 32'h8765_4321, "R6 pa held");

    // R7 masking after capture
    wr(3'd2, 32'h0000_0004);
    chk(1, 3'd3, 32'h0, "R7 irq masked");
    wr(3'd2, 32'h0000_0005);
    chk(1, 3'd3, 32'h1, "R7 irq unmasked");

    // R8 clear
    wr(3'd2, 32'h0000_1000);
    chk(1, 3'd3, 32'h0, "R8 irq cleared");
    chk(0, 3'd3, 32'h0, "R8 cause cleared");
    chk(0, 3'd2, 32'h5, "R8 enables kept, clear reads 0");

    // R10 wrap
    fault(8'h01, 32'h0000_5000, 32'h0, 16'hEF00);
    chk(0, 3'd7, 32'h0000_070F, "R10 decode arb wraps to 7");

    // R9 fault colliding with clear
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h0000_1000;
    flt_valid = 1'b1; flt_cause = 8'h01; flt_iova = 32'h7777_7000; flt_pa = 32'h0; flt_rid = 16'h0;
    @(negedge clk);
    reg_we = 1'b0; flt_valid = 1'b0;
    chk(1, 3'd3, 32'h0, "R9 irq stays low");
    chk(0, 3'd3, 32'h0, "R9 cause empty");

    // R5 new capture after clear, arbiter base
    fault(8'h04, 32'h0000_8FFF, 32'h0000_0040, 16'h0000);
    chk(1, 3'd3, 32'h1, "R5 irq after re-arm");
    chk(0, 3'd3, 32'h4, "R5 cause after re-arm");
    chk(0, 3'd4, 32'h0000_8000, "R5 iova after re-arm");
    chk(0, 3'd7, 32'h0000_0600, "R10 decode arb=6 port=0");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule